// File: doc/BRIEF.md
# GPIO and Interrupt Expander

The block sits behind a narrow synchronous host port and offers two services. It holds a small group of output registers whose bits drive general-purpose output pins, and it collects up to sixteen interrupt sources into one status register. The host finds a register by its index: the byte address on the port, shifted right by one for a 16-bit bus or by two for a 32-bit bus. Output registers reset to a parameter value, take whole-register writes and can be read back.

Each interrupt source passes through a two-flop synchronizer. A rising edge sets that source's pending bit. No mask exists, so every source latches. The host reads the status register to see which sources are pending. It clears all of them by writing a fixed acknowledge pattern to the same register: all ones, or all zeros when `INV_ACK` is set. A summary interrupt line, sensed by the host on its rising edge, comes from a three-state machine:
- `IRQ_IDLE`: output low, nothing pending. It moves to `IRQ_RAISED` once any pending bit is set.
- `IRQ_RAISED`: output high. It stays there until an acknowledge arrives.
- `IRQ_REARM`: output low for one cycle after an acknowledge. It goes to `IRQ_RAISED` if bits are still pending, otherwise to `IRQ_IDLE`.

An acknowledge moves the machine to `IRQ_REARM` from any state. This guarantees the low pulse that the host's edge detector needs.

Top module: `gpio_irq_expander`

## Requirements
- R1: After reset, `gpio_out` equals `INIT_VAL`, `irq_o` is low and the status register reads zero.
- R2: The register index is `addr` shifted right by 1 when `BUS_W` is 16, or by 2 when `BUS_W` is 32. The address bits below the shift are ignored.
- R3: Output pin n is bit (n mod `REG_W`) of register index (`GROUP_START` + n / `REG_W`). A write to that index loads `wdata[REG_W-1:0]`. Without such a write the pins hold their value.
- R4: A read (`cs` and `re` high) returns the addressed register, zero-extended, on `rdata` in the cycle after the read is sampled.
- R5: Writes to an index that is neither an output register nor the status register change nothing. Reads from such an index return zero.
- R6: A source's pending bit sets on a rising edge of that source, three clock edges after the edge is first sampled. It stays set until acknowledged. A source held high does not set the bit again.
- R7: No source can be masked. The status register (index `ACK_IDX`) returns one bit per source, bit i for source i, and 1 means pending.
- R8: Writing `wdata[REG_W-1:0]` equal to the acknowledge pattern (all ones, or all zeros when `INV_ACK`=1) to index `ACK_IDX` clears every pending bit. Any other value written there is ignored.
- R9: A rising edge that would set a pending bit in the same cycle as an acknowledge is kept. The set wins.
- R10: `irq_o` goes high the cycle after any pending bit is set. It is low in the cycle after an acknowledge. It is high only while some bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select for the host port |
| we | input | 1 | Write enable, qualified by cs |
| re | input | 1 | Read enable, qualified by cs |
| addr | input | ADDR_W | Byte address |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Registered read data, valid one cycle after the read |
| irq_src | input | NUM_IRQ | Asynchronous interrupt source inputs |
| gpio_out | output | NUM_OUT*REG_W | Output pins, register by register |
| irq_o | output | 1 | Summary interrupt, rising-edge sensed by the host |

## Verification
The assertions assume the following about the inputs:
- The interrupt sources are low across reset, so no edge is created by the reset itself.
- `ACK_IDX` does not fall inside the output register group.
- `cs` never carries a read and a write in the same cycle.

The bench respects these assumptions:
- Every port input changes only on the falling clock edge.
- Reset is held with all sources low.
- Each host operation is issued alone.
- The set-wins case is produced by timing a source edge three cycles ahead of the acknowledge, not by overlapping commands.

// File: rtl/gpio_exp_pkg.sv
package gpio_exp_pkg;
    typedef enum logic [1:0] {
        IRQ_IDLE   = 2'd0,
        IRQ_RAISED = 2'd1,
        IRQ_REARM  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/exp_edge_sync.sv
module exp_edge_sync #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    output logic [N-1:0] rise
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= src;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/exp_pending.sv
module exp_pending #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr,
    output logic [N-1:0] pend
);
    // set has priority over clear so a coincident event is not lost
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~{N{clr}}) | set;
    end
endmodule

// File: rtl/exp_outregs.sv
module exp_outregs #(
    parameter int REG_W   = 16,
    parameter int NUM_OUT = 2,
    parameter int OFF_W   = 1,
    parameter logic [NUM_OUT*REG_W-1:0] INIT_VAL = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [OFF_W-1:0]         wr_off,
    input  logic [REG_W-1:0]         wr_val,
    input  logic [OFF_W-1:0]         rd_off,
    output logic [REG_W-1:0]         rd_val,
    output logic [NUM_OUT*REG_W-1:0] regs_flat
);
    logic [REG_W-1:0] r_q [NUM_OUT];

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                r_q[g] <= INIT_VAL[g*REG_W +: REG_W];
            else if (wr_en && wr_off == OFF_W'(g))
                r_q[g] <= wr_val;
        end
        assign regs_flat[g*REG_W +: REG_W] = r_q[g];
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_OUT; i++)
            if (rd_off == OFF_W'(i)) rd_val = r_q[i];
    end
endmodule

// File: rtl/exp_irq_fsm.sv
module exp_irq_fsm
    import gpio_exp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic ack,
    output logic irq_o
);
    irq_state_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= IRQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (ack) begin
            st_d = IRQ_REARM;
        end else begin
            unique case (st_q)
                IRQ_IDLE:   if (any_pend) st_d = IRQ_RAISED;
                IRQ_RAISED: st_d = IRQ_RAISED;
                IRQ_REARM:  st_d = any_pend ? IRQ_RAISED : IRQ_IDLE;
                default:    st_d = IRQ_IDLE;
            endcase
        end
    end

    always_comb begin
        irq_o = (st_q == IRQ_RAISED);
    end
endmodule

// File: rtl/gpio_irq_expander.sv
module gpio_irq_expander #(
    parameter int REG_W       = 16,
    parameter int BUS_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int NUM_IRQ     = 16,
    parameter int NUM_OUT     = 2,
    parameter int GROUP_START = 0,
    parameter int ACK_IDX     = 4,
    parameter bit INV_ACK     = 1'b0,
    parameter logic [NUM_OUT*REG_W-1:0] INIT_VAL = {(NUM_OUT*REG_W/2){2'b10}}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs,
    input  logic                     we,
    input  logic                     re,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BUS_W-1:0]         wdata,
    output logic [BUS_W-1:0]         rdata,
    input  logic [NUM_IRQ-1:0]       irq_src,
    output logic [NUM_OUT*REG_W-1:0] gpio_out,
    output logic                     irq_o
);
    localparam int SHIFT = (BUS_W == 32) ? 2 : 1;
    localparam int IDX_W = ADDR_W - SHIFT;
    localparam int OFF_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
    localparam logic [IDX_W-1:0] GRP_LO = IDX_W'(GROUP_START);
    localparam logic [IDX_W-1:0] GRP_HI = IDX_W'(GROUP_START + NUM_OUT - 1);
    localparam logic [IDX_W-1:0] ACK_I  = IDX_W'(ACK_IDX);
    localparam logic [REG_W-1:0] ACK_PAT = INV_ACK ? '0 : '1;

    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   rel;
    logic               hit_grp, hit_ack, wr, rd, ack_fire;
    logic [REG_W-1:0]   rd_val;
    logic [NUM_IRQ-1:0] rise_vec, pend_q;
    logic               unused_lo;

    assign idx       = addr[ADDR_W-1:SHIFT];
    assign unused_lo = ^addr[SHIFT-1:0];
    assign rel       = idx - GRP_LO;
    assign wr        = cs & we;
    assign rd        = cs & re;
    assign hit_grp   = (idx >= GRP_LO) && (idx <= GRP_HI);
    assign hit_ack   = (idx == ACK_I);
    assign ack_fire  = wr && hit_ack && (wdata[REG_W-1:0] == ACK_PAT);

    if (BUS_W > REG_W) begin : g_wide_bus
        logic unused_hi;
        assign unused_hi = ^wdata[BUS_W-1:REG_W];
    end

    exp_outregs #(
        .REG_W(REG_W), .NUM_OUT(NUM_OUT), .OFF_W(OFF_W), .INIT_VAL(INIT_VAL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr & hit_grp), .wr_off(OFF_W'(rel)), .wr_val(wdata[REG_W-1:0]),
        .rd_off(OFF_W'(rel)), .rd_val(rd_val), .regs_flat(gpio_out)
    );

    exp_edge_sync #(.N(NUM_IRQ)) u_sync (
        .clk(clk), .rst_n(rst_n), .src(irq_src), .rise(rise_vec)
    );

    exp_pending #(.N(NUM_IRQ)) u_pend (
        .clk(clk), .rst_n(rst_n), .set(rise_vec), .clr(ack_fire), .pend(pend_q)
    );

    exp_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .any_pend(|pend_q), .ack(ack_fire), .irq_o(irq_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            if (hit_grp)      rdata <= BUS_W'(rd_val);
            else if (hit_ack) rdata <= BUS_W'(pend_q);
            else              rdata <= '0;
        end
    end
endmodule

// File: rtl/gpio_irq_expander_chk.sv
module gpio_irq_expander_chk #(
    parameter int REG_W       = 16,
    parameter int BUS_W       = 16,
    parameter int ADDR_W      = 8,
    parameter int NUM_IRQ     = 16,
    parameter int NUM_OUT     = 2,
    parameter int GROUP_START = 0,
    parameter int ACK_IDX     = 4,
    parameter bit INV_ACK     = 1'b0
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs,
    input logic                     we,
    input logic                     re,
    input logic [ADDR_W-1:0]        addr,
    input logic [BUS_W-1:0]         wdata,
    input logic [BUS_W-1:0]         rdata,
    input logic [NUM_OUT*REG_W-1:0] gpio_out,
    input logic                     irq_o,
    input logic [NUM_IRQ-1:0]       pend_q,
    input logic [NUM_IRQ-1:0]       rise_vec
);
    localparam int SHIFT = (BUS_W == 32) ? 2 : 1;
    localparam logic [REG_W-1:0] PAT = INV_ACK ? '0 : '1;

    int  ix;
    logic ack_seen, unmapped;
    assign ix       = int'(addr >> SHIFT);
    assign ack_seen = cs && we && (ix == ACK_IDX) && (wdata[REG_W-1:0] == PAT);
    assign unmapped = (ix != ACK_IDX) && ((ix < GROUP_START) || (ix >= GROUP_START + NUM_OUT));

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> !irq_o); // R10
    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_q != '0)); // R10
    AST_ACK_CLEARS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> ((pend_q & ~$past(rise_vec)) == '0)); // R8
    AST_PENDING_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_seen |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_seen |=> ((pend_q & $past(rise_vec)) == $past(rise_vec))); // R9
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && re && unmapped) |=> (rdata == '0)); // R5
    AST_GPIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && we) |=> $stable(gpio_out)); // R3
endmodule

bind gpio_irq_expander gpio_irq_expander_chk #(
    .REG_W(REG_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ),
    .NUM_OUT(NUM_OUT), .GROUP_START(GROUP_START), .ACK_IDX(ACK_IDX), .INV_ACK(INV_ACK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .re(re), .addr(addr),
    .wdata(wdata), .rdata(rdata), .gpio_out(gpio_out), .irq_o(irq_o),
    .pend_q(pend_q), .rise_vec(rise_vec)
);

// File: tb/sim_gpio_irq_expander.sv
module sim_gpio_irq_expander;
    localparam int SHIFT = 1;
    localparam int ACKI  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 0, we = 0, re = 0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] irq_src = '0;
    logic [31:0] gpio_out;
    logic        irq_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    gpio_irq_expander u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .re(re), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_src(irq_src),
        .gpio_out(gpio_out), .irq_o(irq_o)
    );

    // behavioural reference model, updated on each rising edge
    logic [15:0] h0, h1, h2, m_pend, m_rise, m_rd;
    logic [15:0] m_reg [2];
    logic        m_irq, m_rd_valid, m_ack;
    int          m_ix;

    always @(posedge clk) begin
        if (!rst_n) begin
            h0 = '0; h1 = '0; h2 = '0; m_pend = '0; m_irq = 1'b0;
            m_reg[0] = 16'hAAAA; m_reg[1] = 16'hAAAA;
            m_rd = '0; m_rd_valid = 1'b0;
        end else begin
            m_ix   = int'(addr) >> SHIFT;
            m_ack  = cs && we && (m_ix == ACKI) && (wdata == 16'hFFFF);
            m_rise = h1 & ~h2;
            m_irq  = !m_ack && (m_pend != 0);
            m_rd_valid = cs && re;
            if (m_rd_valid) begin
                if (m_ix < 2)          m_rd = m_reg[m_ix];
                else if (m_ix == ACKI) m_rd = m_pend;
                else                   m_rd = '0;
            end
            m_pend = m_ack ? m_rise : (m_pend | m_rise);
            if (cs && we && m_ix < 2) m_reg[m_ix] = wdata;
            h2 = h1; h1 = h0; h0 = irq_src;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 model irq_o", {31'd0, irq_o}, {31'd0, m_irq});
            chk("R3 model gpio_out", gpio_out, {m_reg[1], m_reg[0]});
            if (m_rd_valid) chk("R4 model rdata", {16'd0, rdata}, {16'd0, m_rd});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); cs = 1; re = 1; addr = a;
        @(negedge clk); cs = 0; re = 0; d = rdata;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 gpio reset", gpio_out, 32'hAAAA_AAAA);
        chk("R1 irq reset", {31'd0, irq_o}, 32'd0);
        rd(8'h08, d); chk("R1 status reset", {16'd0, d}, 32'd0);

        wr(8'h00, 16'h1234);
        rd(8'h00, d); chk("R4 readback reg0", {16'd0, d}, 32'h1234);
        chk("R3 gpio low group", {16'd0, gpio_out[15:0]}, 32'h1234);
        wr(8'h03, 16'hBEEF);
        chk("R2 addr 3 maps to index 1", gpio_out, 32'hBEEF_1234);
        rd(8'h02, d); chk("R2 addr 2 reads index 1", {16'd0, d}, 32'hBEEF);
        chk("R3 gpio pin 17", {31'd0, gpio_out[17]}, 32'd1);

        wr(8'h06, 16'h5555);
        chk("R5 unmapped write ignored", gpio_out, 32'hBEEF_1234);
        rd(8'h06, d); chk("R5 unmapped read zero", {16'd0, d}, 32'd0);

        @(negedge clk); irq_src[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 irq before pend", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R10 irq rises", {31'd0, irq_o}, 32'd1);
        rd(8'h08, d); chk("R6 pending source 3", {16'd0, d}, 32'h0008);

        wr(8'h08, 16'h1234);
        rd(8'h08, d); chk("R8 wrong pattern ignored", {16'd0, d}, 32'h0008);
        wr(8'h08, 16'h0000);
        rd(8'h08, d); chk("R8 inverted pattern ignored", {16'd0, d}, 32'h0008);

        @(negedge clk); cs = 1; we = 1; addr = 8'h08; wdata = 16'hFFFF;
        @(negedge clk); cs = 0; we = 0;
        chk("R10 irq low after ack", {31'd0, irq_o}, 32'd0);
        rd(8'h08, d); chk("R8 ack clears", {16'd0, d}, 32'd0);
        repeat (5) @(negedge clk);
        chk("R6 held level no retrigger", {31'd0, irq_o}, 32'd0);

        @(negedge clk); irq_src[0] = 1'b1; irq_src[15] = 1'b1;
        repeat (5) @(negedge clk);
        rd(8'h08, d); chk("R7 all sources latch", {16'd0, d}, 32'h8001);

        @(negedge clk); irq_src[5] = 1'b1;
        @(negedge clk);
        @(negedge clk); cs = 1; we = 1; addr = 8'h08; wdata = 16'hFFFF;
        @(negedge clk); cs = 0; we = 0;
        chk("R10 low pulse after ack", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R10 rises again", {31'd0, irq_o}, 32'd1);
        rd(8'h08, d); chk("R9 set wins over ack", {16'd0, d}, 32'h0020);

        wr(8'h08, 16'hFFFF);
        @(negedge clk); irq_src[3] = 1'b0;
        repeat (4) @(negedge clk); irq_src[3] = 1'b1;
        repeat (5) @(negedge clk);
        rd(8'h08, d); chk("R6 new edge sets again", {16'd0, d}, 32'h0008);
        wr(8'h08, 16'hFFFF);
        repeat (2) @(negedge clk);
        chk("R10 idle at end", {31'd0, irq_o}, 32'd0);
        summary();
    end
endmodule